// File: doc/BRIEF.md
# Priority Interrupt Controller Bank

This block gathers thirty-two interrupt request lines and delivers them to a processor on two outputs: an ordinary interrupt and a fast interrupt. Each line has a small per-line configuration word. That word chooses which of the two outputs the line uses, whether the line is sampled as a level or caught on a rising edge, and a five-bit priority. A per-line mask blocks any line. A global gate holds back both outputs until software opens it.

For each output, the block picks the pending, unmasked line with the best priority, raises the output and freezes that line's number. The number stays frozen until software writes the matching acknowledge bit. That write releases the output, clears the line's edge latch and lets arbitration run again on the next cycle.

A simple synchronous register bus carries all configuration, status, source numbers and acknowledges. Read data appears one cycle after the address. When several banks are combined, line n belongs to bank n/32 at bit n%32, and only bank 0 may route lines to the fast output.

Top module: `prio_intc_bank`

## Requirements
- R1: After reset, the mask register (offset 0x04) reads all ones, the global gate (offset 0x14, bit 0) reads 1, every per-line word reads 0, and both outputs are low.
- R2: A 1 in bit k of the mask register keeps line k from being delivered; clearing the bit lets a pending line k through.
- R3: The per-line word of line k is at offset 0x20+4*k. Bit 0 is route (1 = fast output, 0 = ordinary), bit 1 is trigger (1 = edge, 0 = level) and bits 6:2 are the priority. Bits above 6 read as 0.
- R4: With trigger 0, status bit k (offset 0x00) follows input k. With trigger 1, a rising edge on input k sets status bit k, and the bit stays set after the input falls.
- R5: Among candidate lines, the lowest priority value wins. Equal values go to the lower line number.
- R6: While an output is high, its source number (ports and offsets 0x08 ordinary / 0x0C fast, number in the low bits, bit 31 = active) does not change, even if a better line becomes pending.
- R7: Writing offset 0x10 with bit 0 set acknowledges the ordinary output, and bit 1 acknowledges the fast output. The output drops at the same edge, the acknowledged line's edge latch is cleared, and the next winner is delivered one cycle later.
- R8: Fast routing is honoured only when BANK_INDEX is 0. In any other bank, a line with route 1 is delivered on the ordinary output.
- R9: A write to the status offset clears each edge latch whose data bit is 0. Writing 0 clears them all.
- R10: While the global gate is 1, no source is captured and both outputs stay low. Writing 0 enables delivery.
- R11: Read data shows the register addressed at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NUM_LINES | Interrupt request lines |
| bus_addr_i | input | ADDR_W | Register byte address |
| bus_we_i | input | 1 | Write enable |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Ordinary interrupt output |
| fiq_o | output | 1 | Fast interrupt output |
| irq_src_o | output | SRC_W | Frozen ordinary source number |
| fiq_src_o | output | SRC_W | Frozen fast source number |

## Verification
Level requests are driven one line at a time across all thirty-two lines. This separates the line-number encoding and the status mirroring from any arbitration effect. A burst of edges on every line, with a priority permutation, must come out in exact priority order over thirty-two acknowledges, which exposes any arbitration or latch-clear error. A tie between two lines, followed by a later better edge during service, separates the tie rule from the freeze rule. A second bank instance with a non-zero index shows the same routed line landing on the ordinary output rather than the fast one.

// File: rtl/icb_pkg.sv
package icb_pkg;
  localparam logic [7:0] OFS_STATUS   = 8'h00;
  localparam logic [7:0] OFS_MASK     = 8'h04;
  localparam logic [7:0] OFS_IRQ_SRC  = 8'h08;
  localparam logic [7:0] OFS_FIQ_SRC  = 8'h0C;
  localparam logic [7:0] OFS_CTRL     = 8'h10;
  localparam logic [7:0] OFS_GMASK    = 8'h14;
  localparam logic [7:0] OFS_LVL_BASE = 8'h20;

  localparam int CH_IRQ = 0;
  localparam int CH_FIQ = 1;
  localparam int NUM_CH = 2;

  // A candidate beats the current best when nothing is held yet or its
  // priority value is strictly smaller (strictness keeps the lower index).
  function automatic logic beats(input logic [7:0] cand_pri,
                                 input logic [7:0] best_pri,
                                 input logic       have_best);
    return !have_best || (cand_pri < best_pri);
  endfunction
endpackage

// File: rtl/icb_capture.sv
module icb_capture #(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] req_i,
  input  logic [NUM_LINES-1:0] trig_i,
  input  logic [NUM_LINES-1:0] ack_clr_i,
  input  logic                 sts_wr_i,
  input  logic [NUM_LINES-1:0] sts_keep_i,
  output logic [NUM_LINES-1:0] status_o
);
  logic [NUM_LINES-1:0] prev_q;
  logic [NUM_LINES-1:0] lat_q;
  logic [NUM_LINES-1:0] rise;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic keep;
    assign rise[i] = req_i[i] & ~prev_q[i];
    assign keep    = ~ack_clr_i[i] & (~sts_wr_i | sts_keep_i[i]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev_q[i] <= 1'b0;
        lat_q[i]  <= 1'b0;
      end else begin
        prev_q[i] <= req_i[i];
        lat_q[i]  <= (lat_q[i] & keep) | (trig_i[i] & rise[i]);
      end
    end

    assign status_o[i] = trig_i[i] ? lat_q[i] : req_i[i];

    // R4: a rising edge on an edge line is always remembered
    p_edge_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_i[i] && rise[i]) |=> lat_q[i]);
  end
endmodule

// File: rtl/icb_arbiter.sv
module icb_arbiter #(
  parameter int NUM_LINES = 32,
  parameter int PRIO_W    = 5,
  parameter int SRC_W     = 5
) (
  input  logic [NUM_LINES-1:0]        cand_i,
  input  logic [NUM_LINES*PRIO_W-1:0] pri_flat_i,
  output logic                        valid_o,
  output logic [SRC_W-1:0]            idx_o
);
  import icb_pkg::*;

  always_comb begin
    logic [7:0] best;
    logic       have;
    best  = '0;
    have  = 1'b0;
    idx_o = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      logic [7:0] p;
      p = 8'(pri_flat_i[i*PRIO_W +: PRIO_W]);
      if (cand_i[i] && beats(p, best, have)) begin
        best  = p;
        have  = 1'b1;
        idx_o = SRC_W'(i);
      end
    end
    valid_o = have;
  end
endmodule

// File: rtl/icb_channel.sv
module icb_channel #(
  parameter int SRC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             win_valid_i,
  input  logic [SRC_W-1:0] win_idx_i,
  input  logic             ack_i,
  output logic             busy_o,
  output logic [SRC_W-1:0] src_o,
  output logic             take_o,
  output logic             release_o
);
  assign take_o    = !busy_o && enable_i && win_valid_i;
  assign release_o = busy_o && ack_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      src_o  <= '0;
    end else if (release_o) begin
      busy_o <= 1'b0;
    end else if (take_o) begin
      busy_o <= 1'b1;
      src_o  <= win_idx_i;
    end
  end

  // R6: the served source holds until acknowledged
  p_src_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !ack_i) |=> (busy_o && $stable(src_o)));
  // R7: an acknowledge releases the channel at once
  p_ack_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && ack_i) |=> !busy_o);
endmodule

// File: rtl/icb_regs.sv
module icb_regs #(
  parameter int NUM_LINES = 32,
  parameter int PRIO_W    = 5,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int SRC_W     = 5,
  parameter bit FIQ_OK    = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic                        we_i,
  input  logic [DATA_W-1:0]           wdata_i,
  input  logic [NUM_LINES-1:0]        status_i,
  input  logic                        irq_busy_i,
  input  logic [SRC_W-1:0]            irq_src_i,
  input  logic                        fiq_busy_i,
  input  logic [SRC_W-1:0]            fiq_src_i,
  output logic [DATA_W-1:0]           rdata_o,
  output logic [NUM_LINES-1:0]        mask_o,
  output logic                        gmask_o,
  output logic [NUM_LINES-1:0]        route_o,
  output logic [NUM_LINES-1:0]        trig_o,
  output logic [NUM_LINES*PRIO_W-1:0] pri_flat_o,
  output logic                        sts_wr_o,
  output logic                        ack_irq_o,
  output logic                        ack_fiq_o
);
  import icb_pkg::*;

  localparam int LVL_W = PRIO_W + 2;
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_IRQSRC = ADDR_W'(OFS_IRQ_SRC);
  localparam logic [ADDR_W-1:0] A_FIQSRC = ADDR_W'(OFS_FIQ_SRC);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_GMASK  = ADDR_W'(OFS_GMASK);
  localparam logic [ADDR_W-1:0] A_LVL    = ADDR_W'(OFS_LVL_BASE);
  localparam logic [ADDR_W-1:0] A_LVLEND = ADDR_W'(int'(OFS_LVL_BASE) + 4*NUM_LINES);

  logic [ADDR_W-1:0] lvl_off;
  logic              hit_lvl;
  logic [SRC_W-1:0]  lvl_idx;
  logic [PRIO_W-1:0] pri_q [NUM_LINES];

  assign lvl_off = addr_i - A_LVL;
  assign hit_lvl = (addr_i >= A_LVL) && (addr_i < A_LVLEND) && (addr_i[1:0] == 2'b00);
  assign lvl_idx = lvl_off[SRC_W+1:2];

  assign sts_wr_o  = we_i && (addr_i == A_STATUS);
  assign ack_irq_o = we_i && (addr_i == A_CTRL) && wdata_i[0];
  assign ack_fiq_o = we_i && (addr_i == A_CTRL) && wdata_i[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_o  <= '1;
      gmask_o <= 1'b1;
    end else if (we_i) begin
      if (addr_i == A_MASK)  mask_o  <= wdata_i[NUM_LINES-1:0];
      if (addr_i == A_GMASK) gmask_o <= wdata_i[0];
    end
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_lvl
    logic sel;
    assign sel = we_i && hit_lvl && (lvl_idx == SRC_W'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        route_o[i] <= 1'b0;
        trig_o[i]  <= 1'b0;
        pri_q[i]   <= '0;
      end else if (sel) begin
        route_o[i] <= FIQ_OK ? wdata_i[0] : 1'b0;
        trig_o[i]  <= wdata_i[1];
        pri_q[i]   <= wdata_i[2 +: PRIO_W];
      end
    end
    assign pri_flat_o[i*PRIO_W +: PRIO_W] = pri_q[i];
  end

  logic [DATA_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    if (hit_lvl) begin
      rd_next[LVL_W-1:0] = {pri_q[lvl_idx], trig_o[lvl_idx], route_o[lvl_idx]};
    end else begin
      case (addr_i)
        A_STATUS: rd_next[NUM_LINES-1:0] = status_i;
        A_MASK:   rd_next[NUM_LINES-1:0] = mask_o;
        A_IRQSRC: begin
          rd_next[SRC_W-1:0] = irq_src_i;
          rd_next[DATA_W-1]  = irq_busy_i;
        end
        A_FIQSRC: begin
          rd_next[SRC_W-1:0] = fiq_src_i;
          rd_next[DATA_W-1]  = fiq_busy_i;
        end
        A_GMASK:  rd_next[0] = gmask_o;
        default:  rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata_o <= '0;
    else        rdata_o <= rd_next;
  end

  // R8: a bank other than the first never stores fast routing
  if (!FIQ_OK) begin : g_no_fiq
    p_route_forced_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && hit_lvl) |=> (route_o == '0));
  end
endmodule

// File: rtl/prio_intc_bank.sv
module prio_intc_bank #(
  parameter int NUM_LINES  = 32,
  parameter int PRIO_W     = 5,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int BANK_INDEX = 0,
  parameter int SRC_W      = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] req_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic                 bus_we_i,
  input  logic [DATA_W-1:0]    bus_wdata_i,
  output logic [DATA_W-1:0]    bus_rdata_o,
  output logic                 irq_o,
  output logic                 fiq_o,
  output logic [SRC_W-1:0]     irq_src_o,
  output logic [SRC_W-1:0]     fiq_src_o
);
  import icb_pkg::*;

  localparam bit FIQ_OK = (BANK_INDEX == 0);

  logic [NUM_LINES-1:0]        mask, route, trig, status, pending, ack_clr;
  logic [NUM_LINES*PRIO_W-1:0] pri_flat;
  logic                        gmask, sts_wr, ack_irq, ack_fiq;
  logic [NUM_CH-1:0]           ch_ack, ch_busy, ch_take, ch_rel, win_valid;
  logic [SRC_W-1:0]            ch_src  [NUM_CH];
  logic [SRC_W-1:0]            win_idx [NUM_CH];
  logic [NUM_LINES-1:0]        cand    [NUM_CH];

  icb_regs #(
    .NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .SRC_W(SRC_W), .FIQ_OK(FIQ_OK)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .addr_i(bus_addr_i), .we_i(bus_we_i), .wdata_i(bus_wdata_i),
    .status_i(status),
    .irq_busy_i(ch_busy[CH_IRQ]), .irq_src_i(ch_src[CH_IRQ]),
    .fiq_busy_i(ch_busy[CH_FIQ]), .fiq_src_i(ch_src[CH_FIQ]),
    .rdata_o(bus_rdata_o), .mask_o(mask), .gmask_o(gmask),
    .route_o(route), .trig_o(trig), .pri_flat_o(pri_flat),
    .sts_wr_o(sts_wr), .ack_irq_o(ack_irq), .ack_fiq_o(ack_fiq)
  );

  icb_capture #(.NUM_LINES(NUM_LINES)) u_capture (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .trig_i(trig),
    .ack_clr_i(ack_clr), .sts_wr_i(sts_wr),
    .sts_keep_i(bus_wdata_i[NUM_LINES-1:0]), .status_o(status)
  );

  assign pending = status & ~mask;
  assign ch_ack  = {ack_fiq, ack_irq};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign cand[c] = (c == CH_FIQ) ? (pending & route) : (pending & ~route);

    icb_arbiter #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W), .SRC_W(SRC_W)) u_arb (
      .cand_i(cand[c]), .pri_flat_i(pri_flat),
      .valid_o(win_valid[c]), .idx_o(win_idx[c])
    );

    icb_channel #(.SRC_W(SRC_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .enable_i(!gmask),
      .win_valid_i(win_valid[c]), .win_idx_i(win_idx[c]), .ack_i(ch_ack[c]),
      .busy_o(ch_busy[c]), .src_o(ch_src[c]),
      .take_o(ch_take[c]), .release_o(ch_rel[c])
    );

    // R5: the winner is always one of this channel's candidates
    p_winner_is_cand_r5: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid[c] |-> cand[c][win_idx[c]]);
    // R2: a masked line is never taken
    p_masked_not_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ch_take[c] |-> !mask[win_idx[c]]);
    // R10: nothing is captured while the global gate is closed
    p_gate_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (gmask && !ch_busy[c]) |=> !ch_busy[c]);
  end

  assign ack_clr = (ch_rel[CH_IRQ] ? (NUM_LINES'(1) << ch_src[CH_IRQ]) : '0)
                 | (ch_rel[CH_FIQ] ? (NUM_LINES'(1) << ch_src[CH_FIQ]) : '0);

  assign irq_o     = ch_busy[CH_IRQ] & ~gmask;
  assign fiq_o     = ch_busy[CH_FIQ] & ~gmask;
  assign irq_src_o = ch_src[CH_IRQ];
  assign fiq_src_o = ch_src[CH_FIQ];

  if (!FIQ_OK) begin : g_bank_n
    // R8: the fast output stays silent outside the first bank
    p_no_fast_r8: assert property (@(posedge clk) disable iff (!rst_n) !fiq_o);
  end
endmodule

// File: tb/prio_intc_bank_bench.sv
module prio_intc_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] req = '0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_b1;
  logic        irq, fiq, irq_b1, fiq_b1;
  logic [4:0]  isrc, fsrc, isrc_b1, fsrc_b1;
  int checks = 0;
  int fails = 0;
  logic [4:0] prio_tab [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_intc_bank u_prio_intc_bank (
    .clk(clk), .rst_n(rst_n), .req_i(req), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq), .fiq_o(fiq),
    .irq_src_o(isrc), .fiq_src_o(fsrc)
  );

  prio_intc_bank #(.BANK_INDEX(1)) u_prio_intc_bank_b1 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata_b1), .irq_o(irq_b1), .fiq_o(fiq_b1),
    .irq_src_o(isrc_b1), .fiq_src_o(fsrc_b1)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b0;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic pulse(input logic [31:0] v);
    @(negedge clk);
    req = v;
    @(negedge clk);
    req = '0;
  endtask

  function automatic logic [31:0] lvl_word(input logic route, input logic trig, input logic [4:0] p);
    return {25'd0, p, trig, route};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] served;
    cyc(3);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 irq low", {31'd0, irq}, 32'd0);
    check("R1 fiq low", {31'd0, fiq}, 32'd0);
    rd(8'h04, v); check("R1 mask all ones", v, 32'hFFFF_FFFF);
    rd(8'h14, v); check("R1 gate closed", v, 32'd1);
    rd(8'h20 + 8'd4*8'd5, v); check("R1 line word zero", v, 32'd0);

    // R10 gate holds back delivery
    wr(8'h04, 32'd0);
    req = 32'd1 << 3;
    cyc(3);
    check("R10 gated irq", {31'd0, irq}, 32'd0);
    wr(8'h14, 32'd0);
    cyc(2);
    check("R10 opened irq", {31'd0, irq}, 32'd1);
    check("R10 opened src", {27'd0, isrc}, 32'd3);
    req = '0;
    wr(8'h10, 32'd1);

    // R2 mask
    wr(8'h04, 32'd1 << 3);
    req = 32'd1 << 3;
    cyc(3);
    check("R2 masked irq", {31'd0, irq}, 32'd0);
    wr(8'h04, 32'd0);
    cyc(2);
    check("R2 unmasked irq", {31'd0, irq}, 32'd1);
    check("R2 unmasked src", {27'd0, isrc}, 32'd3);
    req = '0;
    wr(8'h10, 32'd1);

    // R4 / R11 level sweep, one line at a time
    for (int k = 0; k < N; k++) begin
      req = 32'd1 << k;
      cyc(2);
      check("R4 level irq", {31'd0, irq}, 32'd1);
      check("R4 level src", {27'd0, isrc}, k);
      rd(8'h00, v); check("R11 status read", v, 32'd1 << k);
      req = '0;
      wr(8'h10, 32'd1);
      cyc(2);
      check("R7 released", {31'd0, irq}, 32'd0);
    end

    // R3 per-line words, permutation priorities, edge trigger
    for (int k = 0; k < N; k++) begin
      prio_tab[k] = 5'((k * 11 + 5) % 32);
      wr(8'h20 + 8'(4 * k), 32'hFFFF_FF80 | lvl_word(1'b0, 1'b1, prio_tab[k]));
    end
    for (int k = 0; k < N; k++) begin
      rd(8'h20 + 8'(4 * k), v);
      check("R3 line word", v, lvl_word(1'b0, 1'b1, prio_tab[k]));
    end

    // R4 edge latch survives input fall; R5/R7 priority order over 32 acks
    wr(8'h14, 32'd1);
    pulse(32'hFFFF_FFFF);
    rd(8'h00, v); check("R4 edge latched", v, 32'hFFFF_FFFF);
    wr(8'h14, 32'd0);
    cyc(2);
    served = '0;
    for (int n = 0; n < N; n++) begin
      int best;
      best = -1;
      for (int k = 0; k < N; k++)
        if (!served[k] && (best < 0 || prio_tab[k] < prio_tab[best])) best = k;
      check("R5 order irq", {31'd0, irq}, 32'd1);
      check("R5 order src", {27'd0, isrc}, best);
      served[best] = 1'b1;
      wr(8'h10, 32'd1);
      cyc(2);
    end
    check("R7 all served", {31'd0, irq}, 32'd0);
    rd(8'h00, v); check("R7 latches cleared", v, 32'd0);

    // R9 status write clears edge latches
    wr(8'h14, 32'd1);
    pulse(32'h0000_0006);
    rd(8'h00, v); check("R9 before clear", v, 32'h6);
    wr(8'h00, 32'd0);
    rd(8'h00, v); check("R9 after clear", v, 32'd0);
    wr(8'h14, 32'd0);
    cyc(3);
    check("R9 nothing delivered", {31'd0, irq}, 32'd0);

    // R8 fast routing: bank 0 fast, other bank ordinary
    wr(8'h20 + 8'd28, lvl_word(1'b1, 1'b0, 5'd0));
    req = 32'd1 << 7;
    cyc(2);
    check("R8 fast out", {31'd0, fiq}, 32'd1);
    check("R8 fast src", {27'd0, fsrc}, 32'd7);
    check("R8 ordinary idle", {31'd0, irq}, 32'd0);
    check("R8 bank1 ordinary", {31'd0, irq_b1}, 32'd1);
    check("R8 bank1 src", {27'd0, isrc_b1}, 32'd7);
    check("R8 bank1 no fast", {31'd0, fiq_b1}, 32'd0);
    rd(8'h0C, v); check("R8 fast src reg", v, 32'h8000_0007);
    req = '0;
    wr(8'h10, 32'd3);
    check("R7 fast released", {31'd0, fiq}, 32'd0);
    check("R7 bank1 released", {31'd0, irq_b1}, 32'd0);

    // R5 tie and R6 freeze
    wr(8'h20 + 8'd16, lvl_word(1'b0, 1'b1, 5'd2));
    wr(8'h20 + 8'd36, lvl_word(1'b0, 1'b1, 5'd2));
    wr(8'h20 + 8'd48, lvl_word(1'b0, 1'b1, 5'd0));
    pulse((32'd1 << 4) | (32'd1 << 9));
    cyc(2);
    check("R5 tie lower line", {27'd0, isrc}, 32'd4);
    pulse(32'd1 << 12);
    cyc(2);
    check("R6 frozen src", {27'd0, isrc}, 32'd4);
    rd(8'h08, v); check("R6 frozen src reg", v, 32'h8000_0004);
    wr(8'h10, 32'd1);
    cyc(2);
    check("R7 next winner", {27'd0, isrc}, 32'd12);
    wr(8'h10, 32'd1);
    cyc(2);
    check("R7 then tie partner", {27'd0, isrc}, 32'd9);
    wr(8'h10, 32'd1);
    cyc(2);
    check("R7 drained", {31'd0, irq}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule